// File: doc/BRIEF.md
# Two-Tap Complemented-Feedback Shift Counter

This block is a shift-register counter for places where a count does not need to be binary: ring pointers, cycle timeouts, cheap pseudo-random sources. On every enabled clock the register moves up by one bit position. The bit that enters at the bottom is the equivalence (XNOR) of two bits of the current value. Their positions are chosen when the block is elaborated. Because the feedback is complemented, the all-zero value sits on the running sequence. A plain reset therefore gives a usable start point. The all-one value is the single state the counter cannot leave.

A parallel load writes any value into the register, and it overrides counting. A flag output reports when the register holds the stuck all-one value, so that surrounding logic can recover it. Some pairs of tap positions produce the longest possible cycle of 2^N-1 states. Other pairs give shorter cycles, and the pair is left to the integrator.

Top module: `xnor_lfsr_ctr`

## Requirements
- R1: A synchronous active-high reset sets every state bit to 0 on the next rising clock edge, and the lock-up flag reads 0 afterwards.
- R2: With reset and load low and enable high, the next state is the current state shifted up one place: bits [N-2:0] move to [N-1:1], and bit 0 receives XNOR of the bits at positions TAP_HI and TAP_LO.
- R3: With reset, load and enable all low, the state keeps its value.
- R4: With reset low and load high, the next state equals load_val whatever the level of enable.
- R5: The all-zero state advances like any other; with the default taps, one enabled step from zero gives the value 1.
- R6: Once the state is all ones, enabled steps without load or reset leave it all ones.
- R7: The lock-up output is 1 exactly when every state bit is 1.
- R8: With N=15 and taps at bits 14 and 0, a counter enabled without a break after reset first returns to zero after 32767 steps.
- R9: With N=8 and taps at bits 7 and 4 (feedback polynomial x^8+x^3+1), a counter enabled without a break after reset first returns to zero after 217 steps, which is fewer than the 255 a maximal choice would give.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, clears the state |
| en | input | 1 | Advance the counter by one step |
| load | input | 1 | Write load_val into the state; takes priority over en |
| load_val | input | WIDTH | Value written when load is high |
| state | output | WIDTH | Current register value |
| lockup | output | 1 | High while the state is all ones |

## Verification
The bench builds two instances. The first is the 15-bit counter with taps 14 and 0. It takes random mixes of load, enable and reset with stepwise comparison against a bench model. Directed cases cover the zero start, the all-one trap and load-over-enable priority, and one uninterrupted run measures the full 32767-step cycle. The second instance is 8 bits wide with taps 7 and 4. It brings a non-maximal 217-step cycle within reach and shows that the tap choice sets the period.

// File: rtl/lfsr_ctr_pkg.sv
package lfsr_ctr_pkg;

    // Per-cycle action applied to the state register.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_STEP  = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_CLEAR = 2'd3
    } lfsr_act_e;

    // Raw control inputs gathered into one bundle.
    typedef struct packed {
        logic rst;
        logic load;
        logic en;
    } lfsr_ctl_t;

    // Priority: reset, then load, then enable, else hold.
    function automatic lfsr_act_e pick_action(input lfsr_ctl_t c);
        if (c.rst) begin
            return ACT_CLEAR;
        end else if (c.load) begin
            return ACT_LOAD;
        end else if (c.en) begin
            return ACT_STEP;
        end
        return ACT_HOLD;
    endfunction

    // Complemented two-input feedback.
    function automatic logic equiv_bit(input logic a, input logic b);
        return ~(a ^ b);
    endfunction

endpackage

// File: rtl/lfsr_ctl_decode.sv
module lfsr_ctl_decode
    import lfsr_ctr_pkg::*;
(
    input  logic      rst,
    input  logic      load,
    input  logic      en,
    output lfsr_act_e act
);
    lfsr_ctl_t ctl;

    always_comb begin
        ctl.rst  = rst;
        ctl.load = load;
        ctl.en   = en;
        act      = pick_action(ctl);
    end
endmodule

// File: rtl/lfsr_feedback.sv
module lfsr_feedback
    import lfsr_ctr_pkg::*;
(
    input  logic tap_a,
    input  logic tap_b,
    output logic fb
);
    always_comb begin
        fb = equiv_bit(tap_a, tap_b);
    end
endmodule

// File: rtl/lfsr_state_reg.sv
module lfsr_state_reg
    import lfsr_ctr_pkg::*;
#(
    parameter int WIDTH = 15
) (
    input  logic             clk,
    input  lfsr_act_e        act,
    input  logic             fb,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] d;

    always_comb begin
        unique case (act)
            ACT_CLEAR: d = '0;
            ACT_LOAD:  d = load_val;
            ACT_STEP:  d = {q[WIDTH-2:0], fb};
            default:   d = q;
        endcase
    end

    always_ff @(posedge clk) begin
        q <= d;
    end
endmodule

// File: rtl/lfsr_lockup_detect.sv
module lfsr_lockup_detect #(
    parameter int WIDTH = 15
) (
    input  logic [WIDTH-1:0] q,
    output logic             stuck
);
    always_comb begin
        stuck = &q;
    end
endmodule

// File: rtl/xnor_lfsr_ctr.sv
module xnor_lfsr_ctr
    import lfsr_ctr_pkg::*;
#(
    parameter int WIDTH  = 15,
    parameter int TAP_HI = 14,
    parameter int TAP_LO = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] state,
    output logic             lockup
);
    lfsr_act_e        act;
    logic             fb;
    logic [WIDTH-1:0] q;

    lfsr_ctl_decode u_dec (
        .rst  (rst),
        .load (load),
        .en   (en),
        .act  (act)
    );

    lfsr_feedback u_fb (
        .tap_a (q[TAP_HI]),
        .tap_b (q[TAP_LO]),
        .fb    (fb)
    );

    lfsr_state_reg #(.WIDTH(WIDTH)) u_reg (
        .clk      (clk),
        .act      (act),
        .fb       (fb),
        .load_val (load_val),
        .q        (q)
    );

    lfsr_lockup_detect #(.WIDTH(WIDTH)) u_lock (
        .q     (q),
        .stuck (lockup)
    );

    assign state = q;
endmodule

// File: rtl/xnor_lfsr_ctr_chk.sv
module xnor_lfsr_ctr_chk #(
    parameter int WIDTH  = 15,
    parameter int TAP_HI = 14,
    parameter int TAP_LO = 0
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             load,
    input logic [WIDTH-1:0] load_val,
    input logic [WIDTH-1:0] state,
    input logic             lockup
);
    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (state == '0 && !lockup)); // R1

    AST_STEP_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (!load && en) |=> (state[WIDTH-1:1] == $past(state[WIDTH-2:0])
                           && state[0] == !($past(state[TAP_HI]) ^ $past(state[TAP_LO])))); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!load && !en) |=> $stable(state)); // R3

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        load |=> (state == $past(load_val))); // R4

    AST_ZERO_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        (!load && en && state == '0) |=> (state != '0)); // R5

    AST_TRAP_STAYS: assert property (@(posedge clk) disable iff (rst)
        (!load && en && lockup) |=> (lockup && $stable(state))); // R6

    AST_FLAG_CLEAR_ON_ZERO: assert property (@(posedge clk) disable iff (rst)
        (state == '0) |-> !lockup); // R7
endmodule

bind xnor_lfsr_ctr xnor_lfsr_ctr_chk #(
    .WIDTH  (WIDTH),
    .TAP_HI (TAP_HI),
    .TAP_LO (TAP_LO)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .load     (load),
    .load_val (load_val),
    .state    (state),
    .lockup   (lockup)
);

// File: tb/xnor_lfsr_ctr_test.sv
module xnor_lfsr_ctr_test;
    localparam int W = 15;
    localparam int W8 = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en = 1'b0;
    logic          load = 1'b0;
    logic [W-1:0]  load_val = '0;
    logic [W-1:0]  state;
    logic          lockup;

    logic          rst8 = 1'b1;
    logic          en8 = 1'b0;
    logic [W8-1:0] state8;
    logic          lockup8;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [W-1:0] exp_q = '0;

    always #2 clk = ~clk;

    xnor_lfsr_ctr #(.WIDTH(W), .TAP_HI(14), .TAP_LO(0)) uut (
        .clk(clk), .rst(rst), .en(en), .load(load), .load_val(load_val),
        .state(state), .lockup(lockup)
    );

    xnor_lfsr_ctr #(.WIDTH(W8), .TAP_HI(7), .TAP_LO(4)) uut_w8 (
        .clk(clk), .rst(rst8), .en(en8), .load(1'b0), .load_val('0),
        .state(state8), .lockup(lockup8)
    );

    function automatic logic [W-1:0] model_next(input logic r, input logic ld,
                                                input logic e, input logic [W-1:0] v,
                                                input logic [W-1:0] s);
        if (r) return '0;
        if (ld) return v;
        if (e) return {s[W-2:0], ~(s[14] ^ s[0])};
        return s;
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic cycle(input logic r, input logic ld, input logic e,
                         input logic [W-1:0] v, input string req);
        @(negedge clk);
        rst = r; load = ld; en = e; load_val = v;
        exp_q = model_next(r, ld, e, v, exp_q);
        @(posedge clk);
        #1;
        check(req, state, exp_q);
        check("R7 lockup", {{(W-1){1'b0}}, lockup}, {{(W-1){1'b0}}, (exp_q == '1)});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int steps;
        void'($urandom(32'd20240611));

        // R1: reset state
        cycle(1'b1, 1'b0, 1'b0, '0, "R1 reset");
        cycle(1'b1, 1'b1, 1'b1, 15'h1234, "R1 reset beats load");

        // R5: zero advances to 1
        cycle(1'b0, 1'b0, 1'b1, '0, "R5 zero step");
        check("R5 value one", state, 15'h0001);

        // R3: hold when idle
        cycle(1'b0, 1'b0, 1'b0, 15'h7777, "R3 hold");

        // R4: load beats enable
        cycle(1'b0, 1'b1, 1'b1, 15'h2A5C, "R4 load with enable");
        check("R4 loaded value", state, 15'h2A5C);

        // R2: steps from loaded value
        for (int i = 0; i < 8; i++) cycle(1'b0, 1'b0, 1'b1, '0, "R2 step");

        // R6/R7: all-ones trap
        cycle(1'b0, 1'b1, 1'b0, '1, "R6 load ones");
        for (int i = 0; i < 5; i++) cycle(1'b0, 1'b0, 1'b1, '0, "R6 trapped");
        check("R6 still ones", state, '1);
        cycle(1'b0, 1'b1, 1'b1, 15'h7FFE, "R7 leave trap via load");
        cycle(1'b0, 1'b0, 1'b1, '0, "R2 step after trap");

        // Random mix, mostly stepping
        for (int i = 0; i < 2000; i++) begin
            logic r, ld, e;
            int pick;
            pick = $urandom_range(0, 99);
            r  = (pick < 2);
            ld = (pick >= 2 && pick < 10);
            e  = ($urandom_range(0, 3) != 0);
            cycle(r, ld, e, W'($urandom), ld ? "R4 random load" : (e ? "R2 random step" : "R3 random hold"));
        end

        // R8: full period from reset, 15-bit
        cycle(1'b1, 1'b0, 1'b0, '0, "R1 reset before period");
        @(negedge clk);
        rst = 1'b0; load = 1'b0; en = 1'b1;
        steps = 0;
        do begin
            @(posedge clk);
            #1;
            steps++;
        end while (state != '0 && steps < 40000);
        check("R8 period 15-bit", W'(steps), W'(32767));
        @(negedge clk);
        en = 1'b0;

        // R9: shorter period, 8-bit with taps 7,4
        @(negedge clk);
        rst8 = 1'b1;
        @(negedge clk);
        check("R1 8-bit reset", {7'd0, state8}, '0);
        rst8 = 1'b0; en8 = 1'b1;
        steps = 0;
        do begin
            @(posedge clk);
            #1;
            steps++;
        end while (state8 != '0 && steps < 1000);
        check("R9 period 8-bit", W'(steps), W'(217));
        @(negedge clk);
        en8 = 1'b0;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule